// File: doc/BRIEF.md
# Debug Trigger Register File

This block keeps the machine-mode registers that program a small 32-bit core's hardware breakpoints and watchpoints. It has a parameterized number of address/data-match triggers, two by default. Software reaches them through one narrow register port: a 2-bit register address, a write enable, write data and combinational read data. A select register chooses the trigger that the data registers act on. Each trigger stores a control word and a match address. The control word is cleaned up as it is written, so fields the block does not support always read back as fixed values.

The stored control and address of every trigger go out on flat buses to the match logic in the core. A per-trigger pulse tells that logic when to re-arm, because a write has really changed the trigger's stored value. A build option chooses between two size-field variants. In the wide variant, bits 22:21 extend the access-size code. In the narrow variant, the size is only the two low bits and bits 22:21 read as zero.

Top module: `dbg_trigger_csr`

## Requirements
- R1: Register address 0 is the select register, 1 is the control word, 2 is the match address and 3 is the third data register. A write takes effect at the rising clock edge while the write enable is high. Read data is combinational from the current state.
- R2: The control word always reads with the type field (bits 31:28) equal to 2 and the debug-mode bit (bit 27) equal to 0, whatever is written.
- R3: Control bits 5, 10:7 (match), 11 (chain), 15:12 (action), 18 (timing), 19 (select), 20 (hit) and 26:23 always read as 0.
- R4: The access bits (load bit 0, store bit 1, execute bit 2) and the privilege bits (U bit 3, S bit 4, M bit 6) are stored exactly as written.
- R5: In the wide variant the size code is {bits 22:21, bits 17:16}. Codes 0, 1, 2, 3 and 5 are kept as written. Any other code stores 0 in both parts.
- R6: The match address register stores all 32 written bits.
- R7: The select register stores all 32 written bits, and reads return the stored value.
- R8: When the select value is NUM_TRIG or larger, control and address reads return 0 and writes to them change no trigger. The third data register always reads 0, and writes to it change nothing.
- R9: After reset the select register is 0, every control word reads 0x2000_0000, every address is 0 and no reconfigure pulse is high.
- R10: A write that changes a trigger's stored control or address raises that trigger's reconfigure bit for exactly the next cycle. A write that leaves the stored value unchanged raises no pulse.
- R11: The exported control and address buses carry every trigger's stored values, trigger i at bits [32*i +: 32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 2 | Register address (0 select, 1 control, 2 address, 3 third data) |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the addressed register |
| trig_ctrl_o | output | NUM_TRIG*32 | Stored control words of all triggers |
| trig_addr_o | output | NUM_TRIG*32 | Stored match addresses of all triggers |
| trig_reconf_o | output | NUM_TRIG | One-cycle pulse per trigger when its stored value changes |

## Verification
The bench builds the block with its defaults: two triggers and the wide size variant. The wide variant makes the size fallback reachable, because codes 4, 6 and higher can only be written when bits 22:21 take part in the code. With two triggers, a select value of 2 is already out of range, and a full-ones select value checks that the range test uses every bit of the select register.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;

   localparam int XLEN = 32;

   typedef enum logic [1:0] {
      REG_SEL  = 2'd0,
      REG_CTRL = 2'd1,
      REG_ADDR = 2'd2,
      REG_AUX  = 2'd3
   } csr_reg_e;

   localparam logic [3:0]  TYPE_ADMATCH = 4'd2;
   localparam logic [31:0] RESET_CTRL   = {TYPE_ADMATCH, 28'h0};
   // access bits 2:0, privilege bits 3, 4 and 6
   localparam logic [31:0] KEEP_MASK    = 32'h0000_005F;
   localparam logic [31:0] TYPE_MASK    = 32'hF800_0000;
   localparam logic [31:0] SIZE_LO_MASK = 32'h0003_0000;
   localparam logic [31:0] SIZE_HI_MASK = 32'h0060_0000;

   function automatic logic size_ok(input logic [3:0] code);
      return (code <= 4'd3) || (code == 4'd5);
   endfunction

endpackage

// File: rtl/dtrig_ctrl_legalize.sv
module dtrig_ctrl_legalize
   import dtrig_pkg::*;
#(
   parameter bit SIZE_EXT = 1'b1
) (
   input  logic [XLEN-1:0] raw,
   output logic [XLEN-1:0] legal
);

   logic [3:0] code;

   generate
      if (SIZE_EXT) begin : g_wide
         assign code = {raw[22:21], raw[17:16]};
      end else begin : g_narrow
         assign code = {2'b00, raw[17:16]};
      end
   endgenerate

   always_comb begin
      legal = RESET_CTRL | (raw & KEEP_MASK);
      if (size_ok(code)) begin
         legal[17:16] = code[1:0];
         if (SIZE_EXT) legal[22:21] = code[3:2];
      end
   end

endmodule

// File: rtl/dtrig_slot.sv
module dtrig_slot
   import dtrig_pkg::*;
#(
   parameter bit SIZE_EXT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_ctrl,
   input  logic            wr_addr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] ctrl_q,
   output logic [XLEN-1:0] addr_q,
   output logic            reconf
);

   localparam logic [XLEN-1:0] ZERO_MASK =
      ~(TYPE_MASK | KEEP_MASK | SIZE_LO_MASK | (SIZE_EXT ? SIZE_HI_MASK : '0));

   logic [XLEN-1:0] ctrl_legal;

   dtrig_ctrl_legalize #(.SIZE_EXT(SIZE_EXT)) u_legal (
      .raw   (wdata),
      .legal (ctrl_legal)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= RESET_CTRL;
         addr_q <= '0;
         reconf <= 1'b0;
      end else begin
         reconf <= 1'b0;
         if (wr_ctrl) begin
            ctrl_q <= ctrl_legal;
            reconf <= (ctrl_legal != ctrl_q);
         end
         if (wr_addr) begin
            addr_q <= wdata;
            reconf <= (wdata != addr_q);
         end
      end
   end

   // R2: type 2, debug-mode clear
   p_type_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[31:27] == 5'b00100);

   // R3: unsupported fields stay zero
   p_zero_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ZERO_MASK) == '0);

   // R5: stored size code is a legal one
   p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      size_ok({ctrl_q[22:21], ctrl_q[17:16]}));

   // R8: control holds without a write aimed at it
   p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_ctrl) |-> $stable(ctrl_q));

   // R10: a pulse always follows a write
   p_reconf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |-> $past(wr_ctrl || wr_addr));

endmodule

// File: rtl/dtrig_rd_mux.sv
module dtrig_rd_mux
   import dtrig_pkg::*;
#(
   parameter int NUM_TRIG = 2
) (
   input  logic [1:0]               csr_addr,
   input  logic [XLEN-1:0]          sel_q,
   input  logic [NUM_TRIG*XLEN-1:0] ctrl_flat,
   input  logic [NUM_TRIG*XLEN-1:0] addr_flat,
   output logic [XLEN-1:0]          rdata
);

   localparam int IDX_W = $clog2(NUM_TRIG);

   logic             in_range;
   logic [IDX_W-1:0] idx;

   assign in_range = sel_q < XLEN'(NUM_TRIG);
   assign idx      = sel_q[IDX_W-1:0];

   always_comb begin
      rdata = '0;
      case (csr_addr)
         REG_SEL:  rdata = sel_q;
         REG_CTRL: if (in_range) rdata = ctrl_flat[idx*XLEN +: XLEN];
         REG_ADDR: if (in_range) rdata = addr_flat[idx*XLEN +: XLEN];
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/dbg_trigger_csr.sv
module dbg_trigger_csr
   import dtrig_pkg::*;
#(
   parameter int NUM_TRIG = 2,
   parameter bit SIZE_EXT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               csr_addr,
   input  logic                     csr_we,
   input  logic [31:0]              csr_wdata,
   output logic [31:0]              csr_rdata,
   output logic [NUM_TRIG*32-1:0]   trig_ctrl_o,
   output logic [NUM_TRIG*32-1:0]   trig_addr_o,
   output logic [NUM_TRIG-1:0]      trig_reconf_o
);

   generate
      if (NUM_TRIG < 2 || NUM_TRIG > 16) begin : g_bad_count
         $error("dbg_trigger_csr: NUM_TRIG must lie in 2..16");
      end
   endgenerate

   logic [XLEN-1:0] sel_q;
   logic            sel_hit_any;

   always_ff @(posedge clk) begin
      if (!rst_n)                            sel_q <= '0;
      else if (csr_we && csr_addr == REG_SEL) sel_q <= csr_wdata;
   end

   assign sel_hit_any = sel_q < XLEN'(NUM_TRIG);

   for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
      logic hit;
      assign hit = sel_hit_any && (sel_q == XLEN'(i));

      dtrig_slot #(.SIZE_EXT(SIZE_EXT)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ctrl (csr_we && hit && csr_addr == REG_CTRL),
         .wr_addr (csr_we && hit && csr_addr == REG_ADDR),
         .wdata   (csr_wdata),
         .ctrl_q  (trig_ctrl_o[i*XLEN +: XLEN]),
         .addr_q  (trig_addr_o[i*XLEN +: XLEN]),
         .reconf  (trig_reconf_o[i])
      );
   end

   dtrig_rd_mux #(.NUM_TRIG(NUM_TRIG)) u_rd (
      .csr_addr  (csr_addr),
      .sel_q     (sel_q),
      .ctrl_flat (trig_ctrl_o),
      .addr_flat (trig_addr_o),
      .rdata     (csr_rdata)
   );

   // R8: out-of-range select reads zero on the data registers
   p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr != REG_SEL && sel_q >= XLEN'(NUM_TRIG)) |-> csr_rdata == '0);

   // R8: third data register reads zero
   p_aux_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      csr_addr == REG_AUX |-> csr_rdata == '0);

   // R10: at most one trigger reconfigures per cycle
   p_reconf_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trig_reconf_o));

   // R7: select changes only on a select write
   p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(csr_we && csr_addr == REG_SEL) |-> $stable(sel_q));

endmodule

// File: tb/dbg_trigger_csr_tb.sv
module dbg_trigger_csr_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    csr_addr = '0;
   logic          csr_we = 1'b0;
   logic [31:0]   csr_wdata = '0;
   logic [31:0]   csr_rdata;
   logic [NT*32-1:0] trig_ctrl_o, trig_addr_o;
   logic [NT-1:0] trig_reconf_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [NT-1:0] last_pulse;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_trigger_csr u_dut (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_ctrl_o(trig_ctrl_o),
      .trig_addr_o(trig_addr_o), .trig_reconf_o(trig_reconf_o)
   );

   typedef struct packed {
      logic [31:0] sel;
      logic [1:0]  addr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic [1:0]  pulse;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{32'd0, 2'd1, 32'hFFFF_FFFF, 32'h2000_005F, 2'b01},
      '{32'd0, 2'd1, 32'h0001_0049, 32'h2001_0049, 2'b01},
      '{32'd0, 2'd1, 32'h0020_0004, 32'h2000_0004, 2'b01},
      '{32'd1, 2'd1, 32'h0021_0042, 32'h2021_0042, 2'b10},
      '{32'd1, 2'd1, 32'hF8F0_0000, 32'h2000_0000, 2'b10},
      '{32'd1, 2'd1, 32'h0003_FF80, 32'h2003_0000, 2'b10},
      '{32'd1, 2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'b10},
      '{32'd0, 2'd2, 32'h0000_1234, 32'h0000_1234, 2'b01},
      '{32'd0, 2'd2, 32'h0000_1234, 32'h0000_1234, 2'b00},
      '{32'd1, 2'd1, 32'h0003_FF80, 32'h2003_0000, 2'b00},
      '{32'd0, 2'd1, 32'h2800_0008, 32'h2000_0008, 2'b01}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr = a; csr_we = 1'b1; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
      last_pulse = trig_reconf_o;
   endtask

   task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
      csr_addr = a; csr_we = 1'b0;
      #1;
      d = csr_rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      csr_rd(2'd0, rd); chk("R9 select", rd, 32'h0);
      chk("R9 ctrl0", trig_ctrl_o[31:0], 32'h2000_0000);
      chk("R9 ctrl1", trig_ctrl_o[63:32], 32'h2000_0000);
      chk("R9 addr", trig_addr_o[31:0] | trig_addr_o[63:32], 32'h0);
      chk("R9 pulse", {30'b0, trig_reconf_o}, 32'h0);
      csr_rd(2'd1, rd); chk("R9 ctrl read", rd, 32'h2000_0000);

      // table walk: R2 R3 R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         csr_wr(2'd0, VECS[i].sel);
         csr_wr(VECS[i].addr, VECS[i].wdata);
         chk("R10 pulse", {30'b0, last_pulse}, {30'b0, VECS[i].pulse});
         csr_rd(VECS[i].addr, rd);
         chk(VECS[i].addr == 2'd1 ? "R2/R3/R4/R5 ctrl" : "R6 addr", rd, VECS[i].exp);
      end

      // R11: exported buses
      chk("R11 ctrl0", trig_ctrl_o[31:0], 32'h2000_0008);
      chk("R11 ctrl1", trig_ctrl_o[63:32], 32'h2003_0000);
      chk("R11 addr0", trig_addr_o[31:0], 32'h0000_1234);
      chk("R11 addr1", trig_addr_o[63:32], 32'hDEAD_BEEF);

      // R1/R7: full select value kept
      csr_wr(2'd0, 32'hFFFF_FFFF);
      csr_rd(2'd0, rd); chk("R1/R7 select", rd, 32'hFFFF_FFFF);

      // R8: out of range select
      csr_rd(2'd1, rd); chk("R8 oob ctrl read", rd, 32'h0);
      csr_rd(2'd2, rd); chk("R8 oob addr read", rd, 32'h0);
      csr_wr(2'd1, 32'h0000_005F);
      chk("R8 oob pulse", {30'b0, last_pulse}, 32'h0);
      csr_wr(2'd2, 32'h5555_AAAA);
      csr_wr(2'd0, 32'd2);
      csr_wr(2'd1, 32'h0000_0007);
      chk("R8 sel2 ctrl0", trig_ctrl_o[31:0], 32'h2000_0008);
      chk("R8 sel2 ctrl1", trig_ctrl_o[63:32], 32'h2003_0000);
      chk("R8 sel2 addr1", trig_addr_o[63:32], 32'hDEAD_BEEF);

      // R8: third data register
      csr_wr(2'd0, 32'd0);
      csr_wr(2'd3, 32'hFFFF_FFFF);
      chk("R8 aux pulse", {30'b0, last_pulse}, 32'h0);
      csr_rd(2'd3, rd); chk("R8 aux read", rd, 32'h0);
      csr_rd(2'd1, rd); chk("R8 ctrl0 untouched", rd, 32'h2000_0008);
      csr_rd(2'd2, rd); chk("R8 addr0 untouched", rd, 32'h0000_1234);

      // R10: pulse lasts one cycle
      csr_wr(2'd2, 32'h0000_0000);
      chk("R10 pulse high", {30'b0, last_pulse}, 32'h1);
      @(negedge clk);
      chk("R10 pulse gone", {30'b0, trig_reconf_o}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule